// File: doc/BRIEF.md
# Transmit Descriptor Ring Fetcher

This block moves outgoing frame data from memory to a byte stream under the control of descriptors that software places in memory. Each descriptor names a data buffer, a byte count and the address of the descriptor that follows it. A descriptor is handed to the hardware by setting an ownership flag in its status word. The fetcher processes every descriptor it owns and hands each one back by clearing that flag. When it reaches a descriptor it does not own, it stops. Because the follow-on address is explicit, software can close the list into a ring by pointing the final entry back at the first one.

Software loads a starting descriptor address while the block is idle. It then pulses a start request while the enable level is high. The fetcher reads the four descriptor words and then the buffer, one 32-bit word at a time, over a simple request/acknowledge memory port. A small unpacker turns each word into bytes and writes them into a local byte queue. The queue drives the output stream, which carries start-of-frame and end-of-frame marks. In store-and-forward mode the queue releases bytes only once the whole frame is held locally. In cut-through mode bytes leave as soon as they arrive. The address of the descriptor in use can be read at any time.

Top module: `txd_ring_fetcher`

## Requirements
- R1: After reset the block is idle: `busy`, `mem_req` and `out_valid` are low and `cur_desc` is zero.
- R2: A `base_load` pulse while idle copies `base_addr` into `cur_desc`. A `base_load` pulse while busy has no effect on `cur_desc`.
- R3: A `kick` pulse while `dma_en` is high and the block is idle makes the first memory access a read of the status word at `cur_desc`. A `kick` while `dma_en` is low causes no memory access.
- R4: If the status word has bit 31 (ownership) clear, the block goes idle with `cur_desc` still pointing at that descriptor and makes no write.
- R5: The descriptor words are status at offset 0, control at offset 4, buffer address at offset 8 and next address at offset 12. The byte count is control bits [11:0]. The buffer is word aligned. Its bytes go out in ascending address order, least significant byte of each word first.
- R6: `out_sof` marks the first byte of a descriptor whose control bit 29 is set. `out_eof` marks the last byte of a descriptor whose control bit 30 is set. No other byte carries either mark.
- R7: After all buffer words of a descriptor are read and unpacked, the block writes the status word back to the descriptor address with bit 31 cleared and all other bits kept. This write comes before any access to the next descriptor.
- R8: If control bit 24 (chained) is set, the next descriptor address is the next-address word. Otherwise it is the current address plus 16.
- R9: A descriptor with a byte count of zero produces no output bytes, is still written back and still advances.
- R10: With `sf_mode` high, no byte of a frame appears at the output until the last buffer word of the descriptor carrying the end mark has been read. With `sf_mode` low, bytes may leave before that read.
- R11: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data`, `out_sof` and `out_eof` hold their values, and no byte is lost or repeated.
- R12: Once raised, `mem_req` stays high with `mem_addr`, `mem_we` and `mem_wdata` unchanged until `mem_ack`.
- R13: If `dma_en` is low when a write-back completes, the block goes idle after that descriptor, with `cur_desc` at the following descriptor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| dma_en | input | 1 | Fetch enable level |
| kick | input | 1 | Start/resume pulse |
| sf_mode | input | 1 | 1: store-and-forward, 0: cut-through |
| base_load | input | 1 | Load `base_addr` into the current-descriptor pointer (idle only) |
| base_addr | input | 32 | Starting descriptor address |
| cur_desc | output | 32 | Address of the current descriptor |
| busy | output | 1 | Walker is not idle |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1: write, 0: read |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access complete; read data valid |
| mem_rdata | input | 32 | Read data |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output byte |
| out_sof | output | 1 | First byte of a frame |
| out_eof | output | 1 | Last byte of a frame |
| out_ready | input | 1 | Sink accepts a byte |

## Verification
A corrupted pointer or descriptor field shows up first in the memory access order. The address that follows a write-back, or the run of buffer reads, goes wrong within a few accesses, so the bench compares the full access trace against a reference model. A miscounted byte counter or unpacker index shows up in the output stream as a missing, extra or misplaced byte or mark before the next frame starts. A wrong write-back value or a missed stop stays visible in memory and in `cur_desc` after the run. A queue commit error shows up as a byte that leaves too early in store-and-forward mode, or as a stream that stalls.

// File: rtl/txd_pkg.sv
// Shared constants and types for the transmit descriptor ring fetcher.
// Assumes 32-bit descriptor words and byte-addressed, word-aligned memory.
package txd_pkg;
    localparam int OWN_BIT   = 31;
    localparam int LAST_BIT  = 30;
    localparam int FIRST_BIT = 29;
    localparam int CHAIN_BIT = 24;
    localparam logic [31:0] DESC_STRIDE = 32'd16;

    typedef enum logic [2:0] {
        W_IDLE, W_STAT, W_CTL, W_BUF, W_NEXT, W_DATA, W_DRAIN, W_BACK
    } walk_state_e;

    typedef struct packed {
        logic       sof;
        logic       eof;
        logic [7:0] data;
    } txd_byte_t;
endpackage

// File: rtl/txd_walker.sv
// Descriptor walker: reads the four descriptor words, fetches buffer words,
// hands each word to the unpacker, writes the status back with ownership
// cleared and follows the chain. Assumes the memory keeps an access pending
// while mem_req is high and answers with a one-cycle mem_ack.
module txd_walker
    import txd_pkg::*;
#(
    parameter int LEN_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dma_en,
    input  logic             kick,
    input  logic             base_load,
    input  logic [31:0]      base_addr,
    output logic [31:0]      cur_desc,
    output logic             busy,
    output logic             mem_req,
    output logic             mem_we,
    output logic [31:0]      mem_addr,
    output logic [31:0]      mem_wdata,
    input  logic             mem_ack,
    input  logic [31:0]      mem_rdata,
    output logic             word_valid,
    output logic [31:0]      word_data,
    output logic [2:0]       word_nbytes,
    output logic             word_first,
    output logic             word_last,
    input  logic             unp_idle
);
    localparam logic [LEN_W-1:0] WORD_BYTES = LEN_W'(4);

    walk_state_e      state_q;
    logic [31:0]      cur_q, stat_q, ptr_q, next_q;
    logic [LEN_W-1:0] left_q;
    logic             first_q, last_q, chain_q, first_word_q;
    logic [2:0]       take;

    // Bytes taken from the current buffer word.
    assign take = (left_q >= WORD_BYTES) ? 3'd4 : 3'(left_q);

    // Request, address and direction for the current state.
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = cur_q;
        mem_wdata = stat_q & ~(32'd1 << OWN_BIT);
        case (state_q)
            W_STAT: mem_req = 1'b1;
            W_CTL:  begin mem_req = 1'b1; mem_addr = cur_q + 32'd4;  end
            W_BUF:  begin mem_req = 1'b1; mem_addr = cur_q + 32'd8;  end
            W_NEXT: begin mem_req = 1'b1; mem_addr = cur_q + 32'd12; end
            W_DATA: begin mem_req = unp_idle; mem_addr = ptr_q; end
            W_BACK: begin mem_req = 1'b1; mem_we = 1'b1; end
            default: ;
        endcase
    end

    assign word_valid  = (state_q == W_DATA) && mem_req && mem_ack;
    assign word_data   = mem_rdata;
    assign word_nbytes = take;
    assign word_first  = first_q && first_word_q;
    assign word_last   = last_q && (left_q <= WORD_BYTES);
    assign cur_desc    = cur_q;
    assign busy        = (state_q != W_IDLE);

    // Walker state, descriptor fields and pointer updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= W_IDLE;
            cur_q        <= '0;
            stat_q       <= '0;
            ptr_q        <= '0;
            next_q       <= '0;
            left_q       <= '0;
            first_q      <= 1'b0;
            last_q       <= 1'b0;
            chain_q      <= 1'b0;
            first_word_q <= 1'b0;
        end else begin
            case (state_q)
                W_IDLE: begin
                    if (base_load) cur_q <= base_addr;
                    if (kick && dma_en) state_q <= W_STAT;
                end
                W_STAT: if (mem_ack) begin
                    stat_q  <= mem_rdata;
                    state_q <= mem_rdata[OWN_BIT] ? W_CTL : W_IDLE;
                end
                W_CTL: if (mem_ack) begin
                    first_q <= mem_rdata[FIRST_BIT];
                    last_q  <= mem_rdata[LAST_BIT];
                    chain_q <= mem_rdata[CHAIN_BIT];
                    left_q  <= mem_rdata[LEN_W-1:0];
                    state_q <= W_BUF;
                end
                W_BUF: if (mem_ack) begin
                    ptr_q   <= {mem_rdata[31:2], 2'b00};
                    state_q <= W_NEXT;
                end
                W_NEXT: if (mem_ack) begin
                    next_q       <= mem_rdata;
                    first_word_q <= 1'b1;
                    state_q      <= (left_q == '0) ? W_BACK : W_DATA;
                end
                W_DATA: if (mem_req && mem_ack) begin
                    ptr_q        <= ptr_q + 32'd4;
                    left_q       <= left_q - LEN_W'(take);
                    first_word_q <= 1'b0;
                    if (left_q <= WORD_BYTES) state_q <= W_DRAIN;
                end
                W_DRAIN: if (unp_idle) state_q <= W_BACK;
                W_BACK: if (mem_ack) begin
                    cur_q   <= chain_q ? next_q : cur_q + DESC_STRIDE;
                    state_q <= dma_en ? W_STAT : W_IDLE;
                end
                default: state_q <= W_IDLE;
            endcase
        end
    end

    // R12: a pending access keeps its request, address and data
    a_r12_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));
    // R7: write-backs target the current descriptor with ownership cleared
    a_r7_wb_clears_own: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we |-> !mem_wdata[OWN_BIT] && mem_addr == cur_desc);
    // R2: the pointer moves only on a completed write-back while busy
    a_r2_cur_stable_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !(mem_ack && mem_we) |=> $stable(cur_desc));
    // R4: no memory traffic while idle
    a_r4_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req);
endmodule

// File: rtl/txd_unpack.sv
// Word-to-byte unpacker: takes one fetched buffer word with a valid-byte
// count and emits its bytes, lowest lane first, one per cycle into the
// queue, attaching frame marks. Assumes a new word arrives only when idle.
module txd_unpack
    import txd_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        word_valid,
    input  logic [31:0] word_data,
    input  logic [2:0]  word_nbytes,
    input  logic        word_first,
    input  logic        word_last,
    output logic        idle,
    output logic        push,
    output txd_byte_t   push_byte,
    input  logic        full
);
    logic [31:0] word_q;
    logic [2:0]  cnt_q;
    logic [1:0]  idx_q;
    logic        first_q, last_q;

    assign idle           = (cnt_q == 3'd0);
    assign push           = !idle && !full;
    assign push_byte.sof  = first_q && (idx_q == 2'd0);
    assign push_byte.eof  = last_q && (cnt_q == 3'd1);
    assign push_byte.data = word_q[{idx_q, 3'b000} +: 8];

    // Load a word or step to the next byte lane.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q  <= '0;
            cnt_q   <= '0;
            idx_q   <= '0;
            first_q <= 1'b0;
            last_q  <= 1'b0;
        end else if (word_valid) begin
            word_q  <= word_data;
            cnt_q   <= word_nbytes;
            idx_q   <= 2'd0;
            first_q <= word_first;
            last_q  <= word_last;
        end else if (push) begin
            cnt_q <= cnt_q - 3'd1;
            idx_q <= idx_q + 2'd1;
        end
    end

    // R5: a word is never handed over while bytes are still pending
    a_r5_load_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |-> idle);
endmodule

// File: rtl/txd_byte_fifo.sv
// Byte queue with a commit pointer. The read side sees only committed bytes.
// In cut-through mode every written byte is committed one cycle later. In
// store-and-forward mode bytes are committed when the end-marked byte is
// written. Assumes a store-and-forward frame fits in DEPTH bytes.
module txd_byte_fifo
    import txd_pkg::*;
#(
    parameter int DEPTH = 256
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      sf_mode,
    input  logic      push,
    input  txd_byte_t push_byte,
    output logic      full,
    output logic      out_valid,
    output txd_byte_t out_byte,
    input  logic      out_ready
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    txd_byte_t       store_q [DEPTH];
    logic [PW-1:0]   wr_q, rd_q, cm_q;
    logic            pop;

    assign full      = (wr_q - rd_q) == PW'(DEPTH);
    assign out_valid = (rd_q != cm_q);
    assign out_byte  = store_q[rd_q[AW-1:0]];
    assign pop       = out_valid && out_ready;

    // Byte storage write port.
    always_ff @(posedge clk) begin
        if (push) store_q[wr_q[AW-1:0]] <= push_byte;
    end

    // Write, read and commit pointers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q <= '0;
            rd_q <= '0;
            cm_q <= '0;
        end else begin
            if (push) wr_q <= wr_q + PW'(1);
            if (pop)  rd_q <= rd_q + PW'(1);
            if (!sf_mode)                   cm_q <= wr_q + PW'(push);
            else if (push && push_byte.eof) cm_q <= wr_q + PW'(1);
        end
    end

    // R11: no write into a full queue
    a_r11_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    // R11: a stalled byte holds still
    a_r11_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_byte));
    // R10: committed bytes never run ahead of written bytes
    a_r10_commit_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (cm_q - rd_q) <= (wr_q - rd_q));
endmodule

// File: rtl/txd_ring_fetcher.sv
// Top of the transmit descriptor ring fetcher: walker, unpacker and byte
// queue. Assumes word-aligned descriptors and buffers and a memory port that
// completes one word access per mem_ack.
module txd_ring_fetcher
    import txd_pkg::*;
#(
    parameter int LEN_W      = 12,
    parameter int FIFO_DEPTH = 256
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        dma_en,
    input  logic        kick,
    input  logic        sf_mode,
    input  logic        base_load,
    input  logic [31:0] base_addr,
    output logic [31:0] cur_desc,
    output logic        busy,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic        mem_ack,
    input  logic [31:0] mem_rdata,
    output logic        out_valid,
    output logic [7:0]  out_data,
    output logic        out_sof,
    output logic        out_eof,
    input  logic        out_ready
);
    logic        word_valid, word_first, word_last, unp_idle;
    logic [31:0] word_data;
    logic [2:0]  word_nbytes;
    logic        push, full;
    txd_byte_t   push_byte, out_byte;

    txd_walker #(.LEN_W(LEN_W)) u_walker (
        .clk(clk), .rst_n(rst_n), .dma_en(dma_en), .kick(kick),
        .base_load(base_load), .base_addr(base_addr),
        .cur_desc(cur_desc), .busy(busy),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .word_valid(word_valid), .word_data(word_data),
        .word_nbytes(word_nbytes), .word_first(word_first),
        .word_last(word_last), .unp_idle(unp_idle)
    );

    txd_unpack u_unpack (
        .clk(clk), .rst_n(rst_n), .word_valid(word_valid),
        .word_data(word_data), .word_nbytes(word_nbytes),
        .word_first(word_first), .word_last(word_last),
        .idle(unp_idle), .push(push), .push_byte(push_byte), .full(full)
    );

    txd_byte_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .sf_mode(sf_mode),
        .push(push), .push_byte(push_byte), .full(full),
        .out_valid(out_valid), .out_byte(out_byte), .out_ready(out_ready)
    );

    assign out_data = out_byte.data;
    assign out_sof  = out_byte.sof;
    assign out_eof  = out_byte.eof;
endmodule

// File: tb/txd_ring_fetcher_bench.sv
module txd_ring_fetcher_bench;
    localparam int LEN_W = 12;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst_n, dma_en, kick, sf_mode, base_load;
    logic [31:0] base_addr, cur_desc, mem_addr, mem_wdata, mem_rdata;
    logic        busy, mem_req, mem_we, mem_ack;
    logic        out_valid, out_sof, out_eof, out_ready;
    logic [7:0]  out_data;

    txd_ring_fetcher u_txd_ring_fetcher (.*);

    int unsigned mem [1024];
    int unsigned shadow [1024];
    logic [32:0] log_q [$];
    logic [32:0] exp_l [$];
    logic [9:0]  got [$];
    logic [9:0]  exp_b [$];
    logic [31:0] exp_cur;
    int errors = 0, checks = 0;
    int lat_max = 0, ready_pct = 100, wait_c = 0;
    logic [31:0] watch_addr = 32'hFFFF_FFFF;
    bit watch_hit = 0, seen_out = 0, watch_at_first = 0;

    function automatic int widx(input logic [31:0] a);
        return int'(a[11:2]);
    endfunction

    task automatic check(input bit ok, input string rq, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    // Memory responder with random latency; logs every access.
    logic        pend_q = 0;
    logic [31:0] pend_addr = 0;
    initial begin
        mem_ack = 0; mem_rdata = 0;
        forever begin
            @(negedge clk);
            if (pend_q && !mem_ack)
                check(mem_req && mem_addr == pend_addr, "R12", "request held", mem_addr, pend_addr);
            if (mem_ack) begin
                mem_ack = 0;
                pend_q = 0;
                wait_c = $urandom_range(lat_max, 0);
            end else if (mem_req) begin
                pend_q = 1; pend_addr = mem_addr;
                if (wait_c > 0) wait_c--;
                else begin
                    mem_ack = 1;
                    log_q.push_back({mem_we, mem_addr});
                    if (mem_we) mem[widx(mem_addr)] = mem_wdata;
                    else begin
                        mem_rdata = mem[widx(mem_addr)];
                        if (mem_addr == watch_addr) watch_hit = 1;
                    end
                end
            end
        end
    end

    // Stream sink with random backpressure.
    bit         prev_stall = 0;
    logic [9:0] prev_val = 0;
    initial begin
        out_ready = 1;
        forever begin
            @(negedge clk);
            if (prev_stall)
                check(out_valid && {out_sof, out_eof, out_data} == prev_val, "R11",
                      "stalled byte held", {out_valid, out_sof, out_eof, out_data}, {1'b1, prev_val});
            out_ready = ($urandom_range(99, 0) < ready_pct);
            if (out_valid && out_ready) begin
                got.push_back({out_sof, out_eof, out_data});
                if (!seen_out) begin seen_out = 1; watch_at_first = watch_hit; end
            end
            prev_stall = out_valid && !out_ready;
            prev_val = {out_sof, out_eof, out_data};
        end
    end

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
        report();
        $finish;
    end

    task automatic put_desc(input logic [31:0] a, input bit own, input bit fst, input bit lst,
                            input bit chn, input int len, input logic [31:0] buff,
                            input logic [31:0] nxt);
        mem[widx(a)]      = {own, 7'h15, 24'h00A5C3};
        mem[widx(a + 4)]  = {1'b0, lst, fst, 4'h0, chn, 12'h0, 12'(len)};
        mem[widx(a + 8)]  = buff;
        mem[widx(a + 12)] = nxt;
        for (int w = 0; w < (len + 3) / 4; w++) mem[widx(buff + 32'(4 * w))] = $urandom;
    endtask

    // Reference walk over a copy of memory.
    task automatic model(input logic [31:0] start, input bit one_only);
        logic [31:0] a, st, ct, bf, nx, wd;
        int len;
        exp_b.delete(); exp_l.delete();
        shadow = mem;
        a = start;
        for (int k = 0; k < 40; k++) begin
            st = shadow[widx(a)];
            exp_l.push_back({1'b0, a});
            if (!st[31]) break;
            ct = shadow[widx(a + 4)]; bf = shadow[widx(a + 8)]; nx = shadow[widx(a + 12)];
            exp_l.push_back({1'b0, a + 32'd4});
            exp_l.push_back({1'b0, a + 32'd8});
            exp_l.push_back({1'b0, a + 32'd12});
            len = int'(ct[LEN_W-1:0]);
            for (int w = 0; w < (len + 3) / 4; w++) exp_l.push_back({1'b0, bf + 32'(4 * w)});
            for (int i = 0; i < len; i++) begin
                wd = shadow[widx(bf + 32'(4 * (i / 4)))];
                exp_b.push_back({ct[29] && i == 0, ct[30] && i == len - 1, wd[8 * (i % 4) +: 8]});
            end
            exp_l.push_back({1'b1, a});
            shadow[widx(a)] = st & 32'h7FFF_FFFF;
            a = ct[24] ? nx : a + 32'd16;
            if (one_only) break;
        end
        exp_cur = a;
    endtask

    // mode 0: plain, 1: drop enable early, 2: base_load while busy
    task automatic run(input int mode);
        got.delete(); log_q.delete(); seen_out = 0; watch_hit = 0;
        @(negedge clk); kick = 1;
        @(negedge clk); kick = 0;
        if (mode == 1) dma_en = 0;
        if (mode == 2) begin
            @(negedge clk); base_load = 1; base_addr = 32'h3F0;
            @(negedge clk); base_load = 0;
        end
        while (busy) @(negedge clk);
        while (out_valid) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    task automatic compare_run(input string rq);
        int bad = -1, mism = 0;
        check(got.size() == exp_b.size(), rq, "byte count", got.size(), exp_b.size());
        for (int i = 0; i < exp_b.size() && i < got.size(); i++)
            if (got[i] != exp_b[i]) begin bad = i; break; end
        check(bad < 0, {rq, " R5 R6"}, "byte/mark", bad < 0 ? 0 : got[bad], bad < 0 ? 0 : exp_b[bad]);
        bad = -1;
        check(log_q.size() == exp_l.size(), {rq, " R7"}, "access count", log_q.size(), exp_l.size());
        for (int i = 0; i < exp_l.size() && i < log_q.size(); i++)
            if (log_q[i] != exp_l[i]) begin bad = i; break; end
        check(bad < 0, {rq, " R3 R7 R8"}, "access order", bad < 0 ? 0 : log_q[bad], bad < 0 ? 0 : exp_l[bad]);
        check(cur_desc == exp_cur, {rq, " R8"}, "cur_desc", cur_desc, exp_cur);
        for (int i = 0; i < 1024; i++) if (mem[i] != shadow[i]) mism++;
        check(mism == 0, {rq, " R7"}, "memory words differing", mism, 0);
    endtask

    initial begin
        void'($urandom(32'd4242));
        rst_n = 0; dma_en = 0; kick = 0; sf_mode = 0; base_load = 0; base_addr = 0;
        for (int i = 0; i < 1024; i++) mem[i] = 0;
        repeat (5) @(negedge clk);
        rst_n = 1;
        repeat (2) @(negedge clk);
        // R1 reset state
        check(!busy && !mem_req && !out_valid, "R1", "idle outputs", {busy, mem_req, out_valid}, 0);
        check(cur_desc == 0, "R1", "cur_desc", cur_desc, 0);

        // R3: kick without enable does nothing
        log_q.delete();
        kick = 1; @(negedge clk); kick = 0;
        repeat (10) @(negedge clk);
        check(log_q.size() == 0 && !busy, "R3", "accesses without enable", log_q.size(), 0);

        // Directed ring: A -> B -> C -> A, base_load while busy ignored (R2)
        put_desc(32'h100, 1, 1, 1, 1, 10, 32'h400, 32'h200);
        put_desc(32'h200, 1, 1, 0, 1, 7,  32'h480, 32'h140);
        put_desc(32'h140, 1, 0, 1, 1, 5,  32'h500, 32'h100);
        base_addr = 32'h100; base_load = 1; @(negedge clk); base_load = 0;
        check(cur_desc == 32'h100, "R2", "load while idle", cur_desc, 32'h100);
        dma_en = 1;
        model(32'h100, 0);
        run(2);
        compare_run("R2 R4");

        // R4: descriptor not owned stops at once
        put_desc(32'h240, 0, 1, 1, 0, 4, 32'h540, 32'h0);
        base_addr = 32'h240; base_load = 1; @(negedge clk); base_load = 0;
        model(32'h240, 0);
        run(0);
        check(log_q.size() == 1 && got.size() == 0, "R4", "accesses on unowned", log_q.size(), 1);
        check(cur_desc == 32'h240, "R4", "cur_desc stays", cur_desc, 32'h240);

        // R9 zero length, R8 sequential advance
        put_desc(32'h240, 1, 1, 1, 0, 0, 32'h580, 32'h0);
        put_desc(32'h250, 1, 1, 1, 0, 6, 32'h5C0, 32'h0);
        put_desc(32'h260, 0, 0, 0, 0, 0, 32'h0, 32'h0);
        model(32'h240, 0);
        run(0);
        compare_run("R9 R8");

        // R10 store-and-forward: first byte only after last word of frame
        put_desc(32'h300, 1, 1, 0, 1, 20, 32'h600, 32'h310);
        put_desc(32'h310, 1, 0, 1, 1, 24, 32'h700, 32'h320);
        put_desc(32'h320, 0, 0, 0, 0, 0, 32'h0, 32'h0);
        watch_addr = 32'h714;
        sf_mode = 1; lat_max = 2;
        base_addr = 32'h300; base_load = 1; @(negedge clk); base_load = 0;
        model(32'h300, 0);
        run(0);
        check(seen_out && watch_at_first, "R10", "sf first byte after last word", watch_at_first, 1);
        compare_run("R10");
        // R10 cut-through contrast
        mem[widx(32'h300)] = mem[widx(32'h300)] | 32'h8000_0000;
        mem[widx(32'h310)] = mem[widx(32'h310)] | 32'h8000_0000;
        sf_mode = 0;
        base_addr = 32'h300; base_load = 1; @(negedge clk); base_load = 0;
        model(32'h300, 0);
        run(0);
        check(seen_out && !watch_at_first, "R10", "cut-through byte early", watch_at_first, 0);
        compare_run("R10");
        watch_addr = 32'hFFFF_FFFF;

        // R13: enable dropped, stop after one descriptor
        put_desc(32'h380, 1, 1, 1, 1, 8, 32'h780, 32'h390);
        put_desc(32'h390, 1, 1, 1, 1, 8, 32'h7C0, 32'h3A0);
        base_addr = 32'h380; base_load = 1; @(negedge clk); base_load = 0;
        model(32'h380, 1);
        run(1);
        compare_run("R13");
        check(mem[widx(32'h390)][31] == 1'b1, "R13", "second still owned", mem[widx(32'h390)][31], 1);

        // Random rings with backpressure and latency
        for (int r = 0; r < 8; r++) begin
            int n;
            n = $urandom_range(4, 1);
            lat_max = $urandom_range(3, 0);
            ready_pct = $urandom_range(100, 40);
            for (int i = 0; i < n; i++)
                put_desc(32'(16 * i), 1, 1'($urandom), 1'($urandom), 1'($urandom),
                         $urandom_range(40, 0), 32'h800 + 32'(64 * i), 32'(16 * (i + 1)));
            put_desc(32'(16 * n), 0, 0, 0, 0, 0, 32'h0, 32'h0);
            dma_en = 1;
            base_addr = 32'h0; base_load = 1; @(negedge clk); base_load = 0;
            model(32'h0, 0);
            run(0);
            compare_run("R5 R6 R11");
        end

        report();
        $finish;
    end
endmodule